// File: doc/BRIEF.md
# Floating-Point Status and Trap Control Register

This block holds the floating-point control and status word of a small processor core. Each time the FPU datapath finishes an operation, it presents that operation's five exception flags (invalid, overflow, underflow, divide-by-zero, inexact) together with a one-cycle completion strobe. The register records the flags of that operation as its cause. It then decides whether the operation has to raise a floating-point exception request to the core, or whether its flags only go into a set of sticky accumulated bits.

A request needs two things: a raised flag whose trap enable is set, and the global trap enable. When a request is raised, the sticky bits are left as they were. Software reads and writes the whole word through a simple port. It uses that port to program the enables and to clear the sticky bits.

Register word layout (NFLAGS = 5, 16 bits): bit 0 is the global trap enable; bits [5:1] are the per-flag trap enables; bits [10:6] are the cause; bits [15:11] are the sticky flags. Within each 5-bit field, bit 0 is invalid, bit 1 overflow, bit 2 underflow, bit 3 divide-by-zero and bit 4 inexact. The flag input uses the same bit order.

Top module: `fpsr_core`

## Requirements
- R1: After reset, the whole register word reads as zero and no trap request is asserted.
- R2: A write stores all 16 bits of the word (global enable bit 0, trap enables [5:1], cause [10:6], sticky [15:11]), and the value can be read back from the cycle after the write.
- R3: On every completion strobe without a same-cycle write, the cause field is replaced by that operation's flags, and all-zero flags clear it.
- R4: A completion whose flags share at least one set bit with the trap enables, while the global enable is 1, asserts the trap request in the following cycle.
- R5: If the global enable is 0, no trap request is raised, whatever the flags and trap enables are.
- R6: If no raised flag has its trap enable set, no trap request is raised, even when the global enable is 1.
- R7: A completion that raises a trap request leaves the sticky bits unchanged.
- R8: A completion that raises no trap request ORs its flags into the sticky bits.
- R9: A write in the same cycle as a completion wins over the flag update: the cause and sticky fields take the written data. The trap decision for that completion still uses the enables held before the write.
- R10: The trap request is a single-cycle pulse. It is asserted only in the cycle after a completion strobe.
- R11: Sticky bits never clear on their own. Only a write of 0 to a bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_done | input | 1 | One-cycle strobe marking a finished FPU operation |
| op_flags | input | 5 | Exception flags of the finished operation |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 16 | Write data for the whole word |
| csr_rdata | output | 16 | Current register word |
| fp_trap | output | 1 | Floating-point exception request pulse |

## Verification
The bench builds the block with its default of five flags, which gives a 16-bit word. With that width, every one of the 32 flag patterns and every trap-enable mask can be reached by random stimulus, so matching and non-matching enable masks, and both settings of the global enable, occur many times. Directed cases cover a write landing in the same cycle as a completion, a trapping completion over non-zero sticky bits, and idle stretches in which the sticky bits must hold.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
    localparam int unsigned FLAG_N = 5;
    // flag bit order within every flag-wide field
    localparam int unsigned FL_INVALID  = 0;
    localparam int unsigned FL_OVERFLOW = 1;
    localparam int unsigned FL_UNDERFLW = 2;
    localparam int unsigned FL_DIVZERO  = 3;
    localparam int unsigned FL_INEXACT  = 4;
endpackage

// File: rtl/fpsr_trap_eval.sv
module fpsr_trap_eval #(
    parameter int unsigned NFLAGS = fpsr_pkg::FLAG_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_done,
    input  logic [NFLAGS-1:0] flags,
    input  logic [NFLAGS-1:0] trap_en,
    input  logic              glob_en,
    output logic              raise
);
    logic [NFLAGS-1:0] hit;

    always_comb begin
        hit   = flags & trap_en;
        raise = op_done && glob_en && (|hit);
    end

    // R5: a cleared global enable blocks every request
    a_r5_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> !raise);
    // R6: no enabled flag, no request
    a_r6_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & trap_en) == '0) |-> !raise);
endmodule

// File: rtl/fpsr_sticky_bank.sv
module fpsr_sticky_bank #(
    parameter int unsigned NFLAGS = fpsr_pkg::FLAG_N
) (
    input  logic [NFLAGS-1:0] cur,
    input  logic [NFLAGS-1:0] flags,
    input  logic              accum,
    input  logic              wr,
    input  logic [NFLAGS-1:0] wr_val,
    output logic [NFLAGS-1:0] nxt
);
    for (genvar i = 0; i < NFLAGS; i++) begin : g_bit
        always_comb begin
            if (wr)
                nxt[i] = wr_val[i];
            else if (accum)
                nxt[i] = cur[i] | flags[i];
            else
                nxt[i] = cur[i];
        end
    end
endmodule

// File: rtl/fpsr_core.sv
module fpsr_core #(
    parameter int unsigned NFLAGS = fpsr_pkg::FLAG_N,
    localparam int unsigned CSR_W = 1 + 3 * NFLAGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_done,
    input  logic [NFLAGS-1:0] op_flags,
    input  logic              csr_we,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  csr_rdata,
    output logic              fp_trap
);
    localparam int unsigned EN_LO  = 1;
    localparam int unsigned CA_LO  = EN_LO + NFLAGS;
    localparam int unsigned ST_LO  = CA_LO + NFLAGS;

    typedef struct packed {
        logic [NFLAGS-1:0] sticky;
        logic [NFLAGS-1:0] cause;
        logic [NFLAGS-1:0] trap_en;
        logic              glob_en;
        logic              trap;
    } state_t;

    state_t            s_d, s_q;
    logic              raise_d;
    logic [NFLAGS-1:0] sticky_d;

    fpsr_trap_eval #(.NFLAGS(NFLAGS)) u_eval (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_done (op_done),
        .flags   (op_flags),
        .trap_en (s_q.trap_en),
        .glob_en (s_q.glob_en),
        .raise   (raise_d)
    );

    fpsr_sticky_bank #(.NFLAGS(NFLAGS)) u_sticky (
        .cur    (s_q.sticky),
        .flags  (op_flags),
        .accum  (op_done && !raise_d),
        .wr     (csr_we),
        .wr_val (csr_wdata[ST_LO +: NFLAGS]),
        .nxt    (sticky_d)
    );

    always_comb begin
        s_d        = s_q;
        s_d.trap   = raise_d;
        s_d.sticky = sticky_d;
        if (op_done)
            s_d.cause = op_flags;
        if (csr_we) begin
            s_d.glob_en = csr_wdata[0];
            s_d.trap_en = csr_wdata[EN_LO +: NFLAGS];
            s_d.cause   = csr_wdata[CA_LO +: NFLAGS];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    always_comb begin
        csr_rdata = {s_q.sticky, s_q.cause, s_q.trap_en, s_q.glob_en};
        fp_trap   = s_q.trap;
    end

    // R10: request only follows a completion
    a_r10_pulse_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        !op_done |=> !fp_trap);
    // R4: enabled flag with global enable yields a request
    a_r4_trap_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && csr_rdata[0] && ((op_flags & csr_rdata[EN_LO +: NFLAGS]) != '0))
        |=> fp_trap);
    // R7: trapping completion keeps sticky bits
    a_r7_sticky_hold_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_trap && !$past(csr_we)) |-> $stable(csr_rdata[ST_LO +: NFLAGS]));
    // R11: no sticky bit clears without a write
    a_r11_no_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we |=> ((csr_rdata[ST_LO +: NFLAGS] & $past(csr_rdata[ST_LO +: NFLAGS]))
                     == $past(csr_rdata[ST_LO +: NFLAGS])));
    // R3: cause follows the completed operation
    a_r3_cause_update: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !csr_we) |=> (csr_rdata[CA_LO +: NFLAGS] == $past(op_flags)));
endmodule

// File: tb/fpsr_core_tb.sv
module fpsr_core_tb;
    localparam int NF = 5;
    localparam int W  = 1 + 3 * NF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_done = 1'b0;
    logic [NF-1:0] op_flags = '0;
    logic          csr_we = 1'b0;
    logic [W-1:0]  csr_wdata = '0;
    logic [W-1:0]  csr_rdata;
    logic          fp_trap;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic          m_gen;
    logic [NF-1:0] m_en, m_cause, m_sticky;

    always #10 clk = ~clk;

    fpsr_core #(.NFLAGS(NF)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_flags(op_flags),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .fp_trap(fp_trap)
    );

    function automatic logic [W-1:0] pack_word(logic g, logic [NF-1:0] e,
                                               logic [NF-1:0] c, logic [NF-1:0] s);
        return {s, c, e, g};
    endfunction

    function automatic logic want_trap(logic od, logic [NF-1:0] fl,
                                       logic g, logic [NF-1:0] e);
        return od && g && ((fl & e) != '0);
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one cycle at a falling edge, check at the next falling edge
    task automatic step(string tag, logic we, logic [W-1:0] wd, logic od, logic [NF-1:0] fl);
        logic t;
        csr_we = we; csr_wdata = wd; op_done = od; op_flags = fl;
        t = want_trap(od, fl, m_gen, m_en);
        if (od) begin
            m_cause = fl;
            if (!t) m_sticky = m_sticky | fl;
        end
        if (we) begin
            m_gen    = wd[0];
            m_en     = wd[1 +: NF];
            m_cause  = wd[1+NF +: NF];
            m_sticky = wd[1+2*NF +: NF];
        end
        @(negedge clk);
        check({tag, " word"}, csr_rdata, pack_word(m_gen, m_en, m_cause, m_sticky));
        check({tag, " trap"}, W'(fp_trap), W'(t));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_gen = 0; m_en = '0; m_cause = '0; m_sticky = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset word", csr_rdata, '0);
        check("R1 reset trap", W'(fp_trap), '0);

        // R2 readback
        step("R2 write", 1, 16'hA5C3, 0, '0);
        step("R2 hold", 0, '0, 0, '0);
        // clear, enable overflow trap globally
        step("R11 write zero clears", 1, pack_word(1, 5'b00010, 0, 0), 0, '0);
        // R8 non-matching flags accumulate, R6 no trap
        step("R6 R8 accumulate", 0, '0, 1, 5'b10001);
        // R4 trap and R7 sticky hold
        step("R4 R7 trap", 0, '0, 1, 5'b00010);
        step("R10 pulse ends", 0, '0, 0, '0);
        // R3 zero flags clear cause
        step("R3 zero cause", 0, '0, 1, 5'b00000);
        // R5 global off
        step("R5 glob off", 1, pack_word(0, 5'b11111, 0, 5'b00100), 0, '0);
        step("R5 no trap", 0, '0, 1, 5'b01000);
        // R9 write in same cycle as a trapping completion (enables before write apply)
        step("R9 arm", 1, pack_word(1, 5'b01000, 0, 0), 0, '0);
        step("R9 collide", 1, pack_word(0, 0, 5'b00001, 5'b10000), 1, 5'b01000);
        step("R9 after", 0, '0, 0, '0);
        // R11 idle hold
        for (int i = 0; i < 4; i++) step("R11 idle", 0, '0, 0, '0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic we, od;
            logic [W-1:0] wd;
            logic [NF-1:0] fl;
            we = ($urandom % 6) == 0;
            od = ($urandom % 2) == 0;
            wd = W'($urandom);
            fl = NF'($urandom);
            step("R3-R11 random", we, wd, od, fl);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule